// File: doc/BRIEF.md
# AES-128 Inverse Cipher Engine

This block turns one 128-bit ciphertext block back into plaintext under a 128-bit key. It works one round at a time and is driven by a small control state machine. A separate key-expansion block produces the eleven round keys. It hands them over as one flat vector, already arranged in the order of use: the last expanded subkey sits in slot 0, and the original key sits in slot 10.

After reset the machine sits in `ST_PRE` for one cycle and then waits in `ST_IDLE`. A start pulse seen in `ST_IDLE` captures the ciphertext and performs the initial key addition with slot 0 (`ST_IDLE -> ST_SUB`). The first round consists of byte rotation and inverse substitution with no column mixing. Every later round begins by adding a key slot and then runs the column mix in four states, one column each (`ST_SUB -> ST_MIX0 -> ST_MIX1 -> ST_MIX2 -> ST_MIX3 -> ST_SUB`). After that come rotation and substitution. The pass through `ST_SUB` with round counter 10 adds slot 10 (the original key), latches the plaintext and moves to `ST_FIN` (`ST_SUB -> ST_FIN`). `ST_FIN` raises the done flag for one cycle and returns through `ST_PRE` to `ST_IDLE` (`ST_FIN -> ST_PRE -> ST_IDLE`). An asynchronous reset from any state returns the machine to `ST_PRE`.

The caller holds the round-key vector steady from the start pulse until done rises.

Top module: `aes128_decrypt`

## Requirements
- R1: While reset is high and in the first cycle after it falls, done is 0 and the plaintext output is 0. The machine spends exactly one cycle in pre-idle after reset and after each completion. A start seen in that cycle is not taken.
- R2: A start is taken only in the idle state, which captures the ciphertext at that edge. A start while a block is in progress is ignored: it changes neither the result nor the timing.
- R3: The key vector holds slot j in bits [128*j+127 : 128*j]. The ciphertext is first XORed with slot 0, the final encryption subkey.
- R4: Byte n of a block is bits [127-8n -: 8], row n mod 4, column n div 4. Inverse row rotation leaves row 0 alone, and output (row r, column c) takes input (row r, column (c-r) mod 4).
- R5: Inverse substitution maps each byte through the inverse affine map (bit i = b[i+2] ^ b[i+5] ^ b[i+7] ^ const 05, indices mod 8) and then the GF(2^8) inverse modulo x^8+x^4+x^3+x+1, with 0 mapping to 0.
- R6: Round 1 has no column mixing. Rounds 2 to 10 each apply the key slot of the previous round and then mix columns 0, 1, 2 and 3 in four consecutive cycles, one column per cycle.
- R7: Column mixing multiplies each 4-byte column by the polynomial with coefficients 0e, 09, 0d, 0b modulo x^4+1, so output byte 0 = 0e*a0 ^ 0b*a1 ^ 0d*a2 ^ 09*a3, with the coefficients rotating for each following row.
- R8: The last step adds slot 10, the original cipher key, and the result is the recovered plaintext.
- R9: Done is high for exactly one cycle, which begins 46 clock edges after the edge that took the start. The earliest next start is taken 3 edges after done rises.
- R10: The plaintext output changes only at the edge that raises done (or on reset), and holds its value until the next completion.
- R11: The key 000102..0f with ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a decrypts to 00112233445566778899aabbccddeeff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start_i | input | 1 | Request to decrypt ct_i, taken in the idle state |
| ct_i | input | 128 | Ciphertext block |
| rkeys_i | input | 1408 | Eleven round keys, slot 0 used first |
| pt_o | output | 128 | Recovered plaintext, held between completions |
| done_o | output | 1 | One-cycle flag marking a finished block |

## Verification
The assertions check the control skeleton on every cycle. They cover the one-cycle pre-idle step, the entry into round 1 on an accepted start, the fixed order of the four column states and the advance of the round counter after them. They also check the direct exit to the final state after round 10, the single-cycle done pulse and the plaintext holding still between completions. The arithmetic cannot be seen by a property: the byte rotation, the substitution, the column mixing and the key-slot order show up only as correct plaintext. Only the bench scenarios exercise them: the known vector, round trips of random blocks through the bench's own encryption, starts issued while busy or held across completions, and a reset in the middle of a block.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_IDLE,
        ST_SUB,
        ST_MIX0,
        ST_MIX1,
        ST_MIX2,
        ST_MIX3,
        ST_FIN
    } dec_state_t;

    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] t;
        acc = 8'h00;
        t   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_xtime(t);
        end
        return acc;
    endfunction

    // a^254 is the field inverse; 0 maps to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] r;
        sq = a;
        r  = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] inv_affine(input logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) begin
            o[i] = b[(i + 2) % 8] ^ b[(i + 5) % 8] ^ b[(i + 7) % 8];
        end
        return o ^ 8'h05;
    endfunction

endpackage

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox (
    input  logic [7:0] byte_i,
    output logic [7:0] byte_o
);
    import aes_dec_pkg::*;

    always_comb begin
        byte_o = gf_inv(inv_affine(byte_i));
    end

endmodule

// File: rtl/aes_inv_shift_sub.sv
module aes_inv_shift_sub #(
    parameter int NROW = 4
) (
    input  logic [8*NROW*NROW-1:0] blk_i,
    output logic [8*NROW*NROW-1:0] blk_o
);
    localparam int NBYTE = NROW * NROW;
    localparam int TOP   = 8 * NBYTE - 1;

    for (genvar r = 0; r < NROW; r++) begin : g_row
        for (genvar c = 0; c < NROW; c++) begin : g_col
            localparam int DST = r + NROW * c;
            localparam int SRC = r + NROW * ((c - r + NROW) % NROW);
            aes_inv_sbox u_box (
                .byte_i (blk_i[TOP - 8*SRC -: 8]),
                .byte_o (blk_o[TOP - 8*DST -: 8])
            );
        end
    end

endmodule

// File: rtl/aes_inv_mix_col.sv
module aes_inv_mix_col (
    input  logic [31:0] col_i,
    output logic [31:0] col_o
);
    import aes_dec_pkg::*;

    logic [7:0] a0, a1, a2, a3;

    always_comb begin
        a0 = col_i[31:24];
        a1 = col_i[23:16];
        a2 = col_i[15:8];
        a3 = col_i[7:0];
        col_o[31:24] = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
        col_o[23:16] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
        col_o[15:8]  = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
        col_o[7:0]   = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
    end

endmodule

// File: rtl/aes128_decrypt.sv
module aes128_decrypt #(
    parameter int ROUNDS = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [127:0]              ct_i,
    input  logic [128*(ROUNDS+1)-1:0] rkeys_i,
    output logic [127:0]              pt_o,
    output logic                      done_o
);
    import aes_dec_pkg::*;

    localparam int NSLOT = ROUNDS + 1;
    localparam int RW    = $clog2(NSLOT + 1);
    localparam logic [RW-1:0] LAST_RND = RW'(ROUNDS);

    dec_state_t     state_q, state_d;
    logic [127:0]   blk_q;
    logic [127:0]   pt_q;
    logic [RW-1:0]  rnd_q;
    logic [127:0]   ss_out;
    logic [127:0]   cur_key;
    logic [127:0]   rnd_res;
    logic [1:0]     col_sel;
    logic [31:0]    col_in;
    logic [31:0]    col_out;

    aes_inv_shift_sub #(.NROW(4)) u_shift_sub (
        .blk_i (blk_q),
        .blk_o (ss_out)
    );

    aes_inv_mix_col u_mix (
        .col_i (col_in),
        .col_o (col_out)
    );

    always_comb begin
        cur_key = rkeys_i[int'(rnd_q)*128 +: 128];
        rnd_res = ss_out ^ cur_key;
        unique case (state_q)
            ST_MIX1: col_sel = 2'd1;
            ST_MIX2: col_sel = 2'd2;
            ST_MIX3: col_sel = 2'd3;
            default: col_sel = 2'd0;
        endcase
        col_in = blk_q[127 - 32*int'(col_sel) -: 32];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRE:  state_d = ST_IDLE;
            ST_IDLE: if (start_i) state_d = ST_SUB;
            ST_SUB:  state_d = (rnd_q == LAST_RND) ? ST_FIN : ST_MIX0;
            ST_MIX0: state_d = ST_MIX1;
            ST_MIX1: state_d = ST_MIX2;
            ST_MIX2: state_d = ST_MIX3;
            ST_MIX3: state_d = ST_SUB;
            ST_FIN:  state_d = ST_PRE;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_PRE;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            blk_q <= '0;
            rnd_q <= '0;
            pt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        blk_q <= ct_i ^ rkeys_i[127:0];
                        rnd_q <= RW'(1);
                    end
                end
                ST_SUB: begin
                    blk_q <= rnd_res;
                    if (rnd_q == LAST_RND) pt_q <= rnd_res;
                end
                ST_MIX0, ST_MIX1, ST_MIX2: begin
                    blk_q[127 - 32*int'(col_sel) -: 32] <= col_out;
                end
                ST_MIX3: begin
                    blk_q[127 - 32*int'(col_sel) -: 32] <= col_out;
                    rnd_q <= rnd_q + RW'(1);
                end
                ST_PRE, ST_FIN: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done_o = (state_q == ST_FIN);
        pt_o   = pt_q;
    end

    AST_PRE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_PRE |=> state_q == ST_IDLE); // R1
    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_SUB && rnd_q == RW'(1))); // R2
    AST_MIX_ORDER: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MIX0 |=> (state_q == ST_MIX1 && $stable(rnd_q))); // R6
    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MIX3 |=> (state_q == ST_SUB && rnd_q == $past(rnd_q) + RW'(1))); // R6
    AST_LAST_NO_MIX: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUB && rnd_q == LAST_RND) |=> done_o); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && state_q == ST_PRE)); // R9
    AST_PT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(pt_o)); // R10

endmodule

// File: tb/aes128_decrypt_test.sv
module aes128_decrypt_test;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 46;

    logic           clk = 1'b0;
    logic           rst;
    logic           start_i;
    logic [127:0]   ct_i;
    logic [1407:0]  rkeys_i;
    logic [127:0]   pt_o;
    logic           done_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes128_decrypt uut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ct_i    (ct_i),
        .rkeys_i (rkeys_i),
        .pt_o    (pt_o),
        .done_o  (done_o)
    );

    // ---------------- behavioural AES helpers (encryption direction) ----------------
    function automatic logic [7:0] xt(input logic [7:0] a);
        return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = xt(x);
        end
        return p;
    endfunction

    function automatic logic [7:0] fwd_sbox(input logic [7:0] a);
        logic [7:0] inv = 8'h01;
        logic [7:0] o;
        for (int e = 0; e < 254; e++) inv = fmul(inv, a);
        if (a == 8'h00) inv = 8'h00;
        for (int i = 0; i < 8; i++)
            o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
        return o ^ 8'h63;
    endfunction

    logic [7:0]   sb_tab [256];
    logic [127:0] rk [11];

    function automatic logic [127:0] sub_shift(input logic [127:0] s);
        logic [127:0] o;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                int src = r + 4*((c + r) % 4);
                o[127 - 8*(r + 4*c) -: 8] = sb_tab[s[127 - 8*src -: 8]];
            end
        return o;
    endfunction

    function automatic logic [127:0] mix(input logic [127:0] s);
        logic [127:0] o;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] a0 = s[127-32*c -: 8];
            logic [7:0] a1 = s[119-32*c -: 8];
            logic [7:0] a2 = s[111-32*c -: 8];
            logic [7:0] a3 = s[103-32*c -: 8];
            o[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
            o[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
            o[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
            o[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
        return o;
    endfunction

    task automatic expand(input logic [127:0] key);
        logic [31:0] w [44];
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127 - 32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb_tab[t[31:24]], sb_tab[t[23:16]], sb_tab[t[15:8]], sb_tab[t[7:0]]};
                t = t ^ {rc, 24'h0};
                rc = xt(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    function automatic logic [127:0] encrypt(input logic [127:0] p);
        logic [127:0] s = p ^ rk[0];
        for (int r = 1; r < 10; r++) s = mix(sub_shift(s)) ^ rk[r];
        return sub_shift(s) ^ rk[10];
    endfunction

    // ---------------- cycle model of the port behaviour ----------------
    typedef enum int {M_PRE, M_IDLE, M_BUSY, M_FIN} mmode_t;
    mmode_t       m_mode;
    int           m_left;
    logic         m_done;
    logic [127:0] m_pt;
    logic [127:0] m_exp_pt;
    logic [127:0] next_pt;

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            m_mode = M_PRE; m_done = 1'b0; m_pt = '0; m_left = 0;
        end else begin
            case (m_mode)
                M_PRE:  m_mode = M_IDLE;
                M_IDLE: if (start_i) begin
                            m_mode = M_BUSY; m_left = LATENCY; m_exp_pt = next_pt;
                        end
                M_BUSY: begin
                            m_left--;
                            if (m_left == 0) begin
                                m_mode = M_FIN; m_done = 1'b1; m_pt = m_exp_pt;
                            end
                        end
                M_FIN:  begin m_mode = M_PRE; m_done = 1'b0; end
            endcase
        end
    end

    task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(done_o === m_done, "R9 done timing", {127'h0, done_o}, {127'h0, m_done});
            check(pt_o === m_pt, "R10 plaintext held/updated", pt_o, m_pt);
            if (m_done)
                check(pt_o === m_exp_pt, "R3 R4 R5 R6 R7 R8 decrypted block", pt_o, m_exp_pt);
        end
    end

    task automatic load(input logic [127:0] key, input logic [127:0] p);
        expand(key);
        for (int j = 0; j < 11; j++) rkeys_i[128*j +: 128] = rk[10 - j];
        ct_i    = encrypt(p);
        next_pt = p;
    endtask

    task automatic wait_idle();
        while (m_mode != M_IDLE) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_block(input logic [127:0] key, input logic [127:0] p);
        load(key, p);
        wait_idle();
        pulse_start();
        while (!m_done) @(negedge clk);
        wait_idle();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [127:0] fips_key;
        logic [127:0] fips_ct;
        logic [127:0] fips_pt;
        rst = 1'b1; start_i = 1'b0; ct_i = '0; rkeys_i = '0; next_pt = '0;
        for (int i = 0; i < 256; i++) sb_tab[i] = fwd_sbox(8'(i));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(done_o === 1'b0, "R1 done in reset", {127'h0, done_o}, 128'h0);
        check(pt_o === '0, "R1 plaintext in reset", pt_o, 128'h0);

        // R1: a start in the first cycle after reset falls is not taken
        load(128'h0, 128'h0);
        rst = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (60) @(negedge clk);
        check(pt_o === '0 && done_o === 1'b0, "R1 R2 start in pre-idle ignored", pt_o, 128'h0);

        // R11: known vector
        fips_key = 128'h000102030405060708090a0b0c0d0e0f;
        fips_ct  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
        fips_pt  = 128'h00112233445566778899aabbccddeeff;
        load(fips_key, fips_pt);
        check(ct_i === fips_ct, "R11 bench encryption of known vector", ct_i, fips_ct);
        ct_i = fips_ct;
        run_block(fips_key, fips_pt);
        check(pt_o === fips_pt, "R11 known vector plaintext", pt_o, fips_pt);

        // round trips of random blocks
        for (int k = 0; k < 5; k++) begin
            logic [127:0] key = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] p   = {$urandom, $urandom, $urandom, $urandom};
            run_block(key, p);
            check(pt_o === p, "R3 R4 R5 R6 R7 R8 round trip", pt_o, p);
        end

        // all-ones key and block
        run_block({128{1'b1}}, {128{1'b1}});
        check(pt_o === {128{1'b1}}, "R5 R7 all-ones round trip", pt_o, {128{1'b1}});

        // R2: start with new ciphertext while busy is ignored
        begin
            logic [127:0] p0 = 128'h0123456789abcdeffedcba9876543210;
            load(128'h2b7e151628aed2a6abf7158809cf4f3c, p0);
            wait_idle();
            pulse_start();
            repeat (10) @(negedge clk);
            ct_i = ~ct_i;
            pulse_start();
            while (!m_done) @(negedge clk);
            check(pt_o === p0, "R2 busy start ignored", pt_o, p0);
            wait_idle();
        end

        // R9: start held high across completions, back-to-back blocks
        begin
            logic [127:0] p1 = 128'hdeadbeefcafef00d0011223344556677;
            load(128'h00112233445566778899aabbccddeeff, p1);
            wait_idle();
            start_i = 1'b1;
            repeat (110) @(negedge clk);
            start_i = 1'b0;
            wait_idle();
            check(pt_o === p1, "R9 back-to-back result", pt_o, p1);
        end

        // R1: reset in the middle of a block aborts it
        load(128'h11111111222222223333333344444444, 128'h5555aaaa5555aaaa5555aaaa5555aaaa);
        wait_idle();
        pulse_start();
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(pt_o === '0 && done_o === 1'b0, "R1 mid-block reset clears", pt_o, 128'h0);
        rst = 1'b0;
        repeat (60) @(negedge clk);
        check(done_o === 1'b0, "R1 no done after abort", {127'h0, done_o}, 128'h0);
        run_block(128'h11111111222222223333333344444444, 128'h5555aaaa5555aaaa5555aaaa5555aaaa);
        check(pt_o === 128'h5555aaaa5555aaaa5555aaaa5555aaaa, "R8 recovery after reset", pt_o,
              128'h5555aaaa5555aaaa5555aaaa5555aaaa);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule